// File: doc/BRIEF.md
# Supervisory Reset Generator with Dip Filter

This block turns a digitised undervoltage flag into an active-low processor reset. The reset output is low from power-up and while the flag says the monitored supply is too low. It is released only after the flag has reported a good supply for a whole programmable reset period, counted in clock cycles.

When reset is released, short undervoltage dips are filtered out. A dip that lasts longer than a programmable filter count is treated as a fault. A fault drives reset low for one complete reset period, whatever the input does during that time. At the end of that period, reset is released if the supply is good again. If the supply is still low, reset stays low until the supply recovers and a fresh reset period has been counted.

The flag first passes through a two-flop synchroniser. Both durations come from configuration inputs and are compared live against the internal counters.

Top module: `supervisor_reset`

## Requirements
- R1: While `porClrN` is low, `rstOutN` is low. The clear acts asynchronously, without waiting for a clock edge. After the clear is released with `belowThresh` at 0, `rstOutN` is still low 10 edges later and high after edge 11 (`resetPeriod` = 8).
- R2: `belowThresh` = 1 means undervoltage. While it is held at 1, `rstOutN` (0 = reset asserted) stays low indefinitely.
- R3: When `belowThresh` goes to 0 with reset held, `rstOutN` rises after clock edge `resetPeriod`+3, counted from the first edge that samples the good level. That is 2 synchroniser edges, 1 edge to start counting, then `resetPeriod` counting edges. Reset only rises after a cycle in which the synchronised input was good.
- R4: If the synchronised input goes low while the reset period is being counted, the count is abandoned and restarts from zero when the input is good again. This holds even when the low arrives in the same cycle that the count would have completed.
- R5: While reset is released, a dip of at most `filterCount` cycles (with `filterCount` > 0) leaves `rstOutN` high.
- R6: While reset is released, a dip of `filterCount`+1 cycles or longer drives `rstOutN` low after edge `filterCount`+3, counted from the first edge that samples the dip. Reset only falls after a cycle in which the synchronised input was low.
- R7: After a qualified fault, reset stays low for exactly `resetPeriod` cycles and is then released if the input is good. Any low phase lasts at least `resetPeriod` cycles.
- R8: If the input is still low when the fault period ends, reset stays low until the input recovers. It is then released only after a fresh full reset period.
- R9: With `filterCount` = 0, any single synchronised low cycle while reset is released is a fault. `rstOutN` goes low after edge 3, counted from the first edge that samples the dip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| porClrN | input | 1 | Asynchronous active-low power-on clear |
| belowThresh | input | 1 | 1 = monitored voltage below threshold (asynchronous) |
| resetPeriod | input | CNT_W | Reset period in cycles |
| filterCount | input | CNT_W | Longest ignored dip in cycles |
| rstOutN | output | 1 | Active-low reset to the processor |

## Verification
Two decisions can land on the same clock edge.

The first is the reset-period counter reaching its end while the synchronised input turns low again. To provoke this, the bench holds the input good for exactly `resetPeriod` cycles and then drops it. The low level then reaches the control on the very edge where the count would finish. The result is judged by requiring reset to stay low two cycles later rather than briefly releasing.

The second case is the end of a fault period while the input is still low. This is judged by requiring that release waits for a full fresh period after the input recovers.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_COUNT,
    ST_RUN,
    ST_FILTER,
    ST_FAULT
  } supvState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic periodClr;
    logic periodInc;
    logic filtClr;
    logic filtInc;
  } supvStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lowSync;
    logic periodDone;
    logic filterDone;
    logic filterZero;
  } supvFlag_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             porClrN,
  input  logic             belowThresh,
  input  logic [CNT_W-1:0] resetPeriod,
  input  logic [CNT_W-1:0] filterCount,
  input  supvStrobe_t      strobes,
  output supvFlag_t        flags
);

  localparam int CMP_W = CNT_W + 1;

  logic [SYNC_N-1:0] syncReg;
  logic [CNT_W-1:0]  periodCnt;
  logic [CNT_W-1:0]  filtCnt;
  logic [CMP_W-1:0]  periodNext;
  logic [CMP_W-1:0]  filtNext;

  // synchroniser, reset to the pessimistic "below" level
  generate
    for (genvar g = 0; g < SYNC_N; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge porClrN) begin
          if (!porClrN) syncReg[0] <= 1'b1;
          else          syncReg[0] <= belowThresh;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge porClrN) begin
          if (!porClrN) syncReg[g] <= 1'b1;
          else          syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge porClrN) begin
    if (!porClrN) begin
      periodCnt <= '0;
    end else if (strobes.periodClr) begin
      periodCnt <= '0;
    end else if (strobes.periodInc) begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porClrN) begin
    if (!porClrN) begin
      filtCnt <= '0;
    end else if (strobes.filtClr) begin
      filtCnt <= '0;
    end else if (strobes.filtInc) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  assign periodNext = {1'b0, periodCnt} + CMP_W'(1);
  assign filtNext   = {1'b0, filtCnt} + CMP_W'(1);

  always_comb begin
    flags.lowSync    = syncReg[SYNC_N-1];
    flags.periodDone = periodNext >= {1'b0, resetPeriod};
    flags.filterDone = filtNext >= {1'b0, filterCount};
    flags.filterZero = (filterCount == '0);
  end

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        porClrN,
  input  supvFlag_t   flags,
  output supvStrobe_t strobes,
  output logic        rstOutN
);

  supvState_e state;
  supvState_e nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_HOLD: begin
        strobes.periodClr = 1'b1;
        if (!flags.lowSync) nextState = ST_COUNT;
      end
      ST_COUNT: begin
        // a low input wins over a completing count
        if (flags.lowSync)         nextState = ST_HOLD;
        else if (flags.periodDone) nextState = ST_RUN;
        else                       strobes.periodInc = 1'b1;
      end
      ST_RUN: begin
        strobes.periodClr = 1'b1;
        strobes.filtClr   = 1'b1;
        if (flags.lowSync) nextState = flags.filterZero ? ST_FAULT : ST_FILTER;
      end
      ST_FILTER: begin
        strobes.periodClr = 1'b1;
        if (!flags.lowSync)        nextState = ST_RUN;
        else if (flags.filterDone) nextState = ST_FAULT;
        else                       strobes.filtInc = 1'b1;
      end
      ST_FAULT: begin
        // full period regardless of the input
        if (flags.periodDone) nextState = flags.lowSync ? ST_HOLD : ST_RUN;
        else                  strobes.periodInc = 1'b1;
      end
      default: nextState = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge porClrN) begin
    if (!porClrN) begin
      state   <= ST_HOLD;
      rstOutN <= 1'b0;
    end else begin
      state   <= nextState;
      rstOutN <= (nextState == ST_RUN) || (nextState == ST_FILTER);
    end
  end

endmodule

// File: rtl/supervisor_reset.sv
module supervisor_reset
  import supv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             porClrN,
  input  logic             belowThresh,
  input  logic [CNT_W-1:0] resetPeriod,
  input  logic [CNT_W-1:0] filterCount,
  output logic             rstOutN
);

  supvStrobe_t strobes;
  supvFlag_t   flags;
  logic        lowSync;

  assign lowSync = flags.lowSync;

  supv_datapath #(
    .CNT_W (CNT_W),
    .SYNC_N(SYNC_N)
  ) uDatapath (
    .clk        (clk),
    .porClrN    (porClrN),
    .belowThresh(belowThresh),
    .resetPeriod(resetPeriod),
    .filterCount(filterCount),
    .strobes    (strobes),
    .flags      (flags)
  );

  supv_ctrl uCtrl (
    .clk    (clk),
    .porClrN(porClrN),
    .flags  (flags),
    .strobes(strobes),
    .rstOutN(rstOutN)
  );

endmodule

// File: rtl/supv_reset_checker.sv
module supv_reset_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             porClrN,
  input logic [CNT_W-1:0] resetPeriod,
  input logic [CNT_W-1:0] filterCount,
  input logic             rstOutN,
  input logic             lowSync
);

  localparam int LC_W = CNT_W + 1;

  logic [LC_W-1:0] lowCycles;

  always_ff @(posedge clk or negedge porClrN) begin
    if (!porClrN)             lowCycles <= '0;
    else if (rstOutN)         lowCycles <= '0;
    else if (lowCycles != '1) lowCycles <= lowCycles + 1'b1;
  end

  assert_clear_low_R1: assert property (@(posedge clk)
    !porClrN |-> !rstOutN);

  assert_release_good_R3: assert property (@(posedge clk) disable iff (!porClrN)
    $rose(rstOutN) |-> !$past(lowSync));

  assert_fall_on_low_R6: assert property (@(posedge clk) disable iff (!porClrN)
    $fell(rstOutN) |-> $past(lowSync));

  assert_full_period_R7: assert property (@(posedge clk) disable iff (!porClrN)
    $rose(rstOutN) |-> (lowCycles >= {1'b0, resetPeriod}));

  assert_zero_filter_R9: assert property (@(posedge clk) disable iff (!porClrN)
    (rstOutN && lowSync && (filterCount == '0)) |=> !rstOutN);

endmodule

bind supervisor_reset supv_reset_checker #(.CNT_W(CNT_W)) uChecker (
  .clk        (clk),
  .porClrN    (porClrN),
  .resetPeriod(resetPeriod),
  .filterCount(filterCount),
  .rstOutN    (rstOutN),
  .lowSync    (lowSync)
);

// File: tb/supervisor_reset_test.sv
module supervisor_reset_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int VEC_N      = 27;

  typedef struct packed {
    logic       below;
    logic [7:0] hold;
    logic       expOut;
    logic [3:0] req;
  } vec_t;

  // resetPeriod = 8, filterCount = 3; hold = edges waited before sampling
  localparam vec_t VECS [VEC_N] = '{
    '{1'b1, 8'd5,  1'b0, 4'd2},  // R2 held while below
    '{1'b0, 8'd10, 1'b0, 4'd3},  // R3 still counting at P+2
    '{1'b0, 8'd1,  1'b1, 4'd3},  // R3 released at P+3
    '{1'b0, 8'd5,  1'b1, 4'd3},
    '{1'b1, 8'd3,  1'b1, 4'd5},  // R5 dip of F cycles
    '{1'b0, 8'd6,  1'b1, 4'd5},  // R5 ignored
    '{1'b1, 8'd4,  1'b1, 4'd6},  // R6 dip of F+1 cycles
    '{1'b0, 8'd2,  1'b0, 4'd6},  // R6 low after edge F+3
    '{1'b0, 8'd7,  1'b0, 4'd7},  // R7 still in fault period
    '{1'b0, 8'd1,  1'b1, 4'd7},  // R7 released after exactly P
    '{1'b1, 8'd6,  1'b0, 4'd6},
    '{1'b1, 8'd10, 1'b0, 4'd8},  // R8 period over, input still low
    '{1'b1, 8'd20, 1'b0, 4'd2},
    '{1'b0, 8'd10, 1'b0, 4'd8},  // R8 fresh period
    '{1'b0, 8'd1,  1'b1, 4'd8},
    '{1'b1, 8'd20, 1'b0, 4'd8},
    '{1'b0, 8'd6,  1'b0, 4'd4},  // R4 counting
    '{1'b1, 8'd1,  1'b0, 4'd4},  // R4 one-cycle drop
    '{1'b0, 8'd10, 1'b0, 4'd4},  // R4 restarted
    '{1'b0, 8'd1,  1'b1, 4'd4},
    '{1'b1, 8'd20, 1'b0, 4'd2},
    '{1'b0, 8'd8,  1'b0, 4'd4},  // R4 low reaches control on done edge
    '{1'b1, 8'd1,  1'b0, 4'd4},
    '{1'b1, 8'd2,  1'b0, 4'd4},
    '{1'b1, 8'd10, 1'b0, 4'd4},
    '{1'b0, 8'd10, 1'b0, 4'd4},
    '{1'b0, 8'd1,  1'b1, 4'd4}
  };

  logic             clk = 1'b0;
  logic             porClrN;
  logic             belowThresh;
  logic [CNT_W-1:0] resetPeriod;
  logic [CNT_W-1:0] filterCount;
  logic             rstOutN;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supervisor_reset #(.CNT_W(CNT_W)) uut (
    .clk        (clk),
    .porClrN    (porClrN),
    .belowThresh(belowThresh),
    .resetPeriod(resetPeriod),
    .filterCount(filterCount),
    .rstOutN    (rstOutN)
  );

  task automatic checkOut(input logic expv, input int req);
    checks++;
    if (rstOutN !== expv) begin
      failures++;
      $display("FAIL R%0d: rstOutN=%0b expected=%0b at %0t", req, rstOutN, expv, $time);
    end
  endtask

  task automatic runEdges(input logic lvl, input int n);
    belowThresh = lvl;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    porClrN     = 1'b1;
    belowThresh = 1'b1;
    resetPeriod = CNT_W'(8);
    filterCount = CNT_W'(3);
    #2 porClrN = 1'b0;
    #1 checkOut(1'b0, 1);           // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut(1'b0, 1);              // R1 held while clear low
    porClrN = 1'b1;

    for (int i = 0; i < VEC_N; i++) begin
      runEdges(VECS[i].below, int'(VECS[i].hold));
      checkOut(VECS[i].expOut, int'(VECS[i].req));
    end

    // R9: zero filter count, single-cycle dip is a fault
    filterCount = '0;
    runEdges(1'b1, 1);
    runEdges(1'b0, 2);
    checkOut(1'b0, 9);
    runEdges(1'b0, 7);
    checkOut(1'b0, 9);
    runEdges(1'b0, 1);
    checkOut(1'b1, 9);
    filterCount = CNT_W'(3);

    // R1: asynchronous clear while released
    runEdges(1'b0, 3);
    checkOut(1'b1, 1);
    porClrN = 1'b0;
    #1 checkOut(1'b0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    porClrN = 1'b1;
    runEdges(1'b0, 10);
    checkOut(1'b0, 1);
    runEdges(1'b0, 1);
    checkOut(1'b1, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule